// File: doc/BRIEF.md
# PS/2 Host Command Transmitter

This block lets a host controller send one command byte to a device on a two-wire, open-collector PS/2 link, such as a mouse. Each wire is controlled through a pull-low enable. When the enable is set, the wire is driven to 0. When it is clear, the wire is released and the external pull-up holds it high. The block reads the wire levels through its own synchronizer and glitch filter.

A one-cycle `tx_start` pulse takes a byte from `tx_data`. The block first holds the clock wire low for a programmable inhibit time. It then releases the clock wire and pulls the data wire low, which forms the start bit. From that point the device generates every clock pulse. On each filtered falling clock edge from the device, the block moves to the next part of the frame, in this order:

- the eight data bits, least significant first;
- an odd parity bit;
- a released data wire.

At the last edge the block reads the device's acknowledge from the data wire. `done` pulses when the transfer ends. `ack_err` reports a missing acknowledge, and `timeout_err` reports a device that stopped clocking.

Top module: `ps2_host_tx`

## Requirements
- R1: During and right after reset, both pull-low enables are clear, and `busy`, `done`, `ack_err` and `timeout_err` are 0.
- R2: A `tx_start` pulse while idle sets `busy` and the clock pull-low enable from the next clock edge. The clock enable stays set for exactly INHIBIT_CYCLES cycles.
- R3: On the edge where the inhibit ends, the clock enable clears and the data enable sets. This is the start bit.
- R4: Once the start bit is out, the clock pull-low enable stays clear until the block is idle again.
- R5: Device falling edges 1 to 8 each put the next data bit on the wire, bit 0 first. A 0 bit sets the data pull-low enable and a 1 bit clears it. The data enable changes at no other time during the transfer.
- R6: Edge 9 presents the parity bit. The parity bit makes the total count of ones across the eight data bits and the parity bit odd.
- R7: Edge 10 releases the data wire: the data pull-low enable clears.
- R8: At edge 11 the filtered data level is sampled. In that cycle `done` pulses high for one cycle and `busy` drops. `ack_err` becomes 1 if the sampled level was high (no acknowledge) and 0 if it was low.
- R9: A change on either wire acts on the outputs SYNC_STAGES+FILT_LEN+1 clock edges after it is first sampled. With the default values this is 6 edges.
- R10: A low pulse on the clock wire that lasts fewer than FILT_LEN cycles is not counted as an edge. A pulse of exactly FILT_LEN cycles is counted.
- R11: If no accepted falling edge arrives for TIMEOUT_CYCLES cycles after the start bit or after the last edge, the block releases both wires. In that cycle it sets `timeout_err`, pulses `done` and clears `busy`.
- R12: A `tx_start` pulse while `busy` is high is ignored. Both the frame in progress and its timing are unchanged.
- R13: `ack_err` and `timeout_err` hold their values while idle. Both are cleared by the next accepted `tx_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 8 | Command byte, taken when a start is accepted |
| tx_start | input | 1 | One-cycle request to send `tx_data` |
| ps2_clk_in | input | 1 | Level seen on the PS/2 clock wire |
| ps2_dat_in | input | 1 | Level seen on the PS/2 data wire |
| ps2_clk_pull | output | 1 | 1 pulls the clock wire low; 0 releases it |
| ps2_dat_pull | output | 1 | 1 pulls the data wire low; 0 releases it |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |
| ack_err | output | 1 | The last transfer ended without a device acknowledge |
| timeout_err | output | 1 | The last transfer was ended by the clock timeout |

## Verification
A wrong edge count or a frame shifted by one bit shows up at `ps2_dat_pull` within one filter latency of the device edge where the wrong bit is presented. It is therefore caught well before the acknowledge phase. A bad inhibit or timeout counter moves the release of `ps2_clk_pull`, or the timeout `done` pulse, by whole cycles. Comparing the outputs every cycle exposes such an error on the exact edge where it happens. A filter that lets a short glitch through advances the data bit early, which is visible in the same way.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

  localparam int DATA_W     = 8;
  // data bits, parity, final release slot
  localparam int FRAME_W    = DATA_W + 2;
  // edges after the start bit: frame slots plus the acknowledge sample
  localparam int LAST_EDGE  = FRAME_W + 1;
  localparam int EDGE_W     = $clog2(LAST_EDGE + 1);

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_INHIBIT = 2'd1,
    ST_XFER    = 2'd2
  } tx_state_e;

  // parity bit that makes the nine-bit word carry an odd count of ones
  function automatic logic odd_parity(input logic [DATA_W-1:0] d);
    return ~(^d);
  endfunction

  // frame as shifted out from bit 0: data LSB first, parity, release (1)
  function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_W-1:0] d);
    return {1'b1, odd_parity(d), d};
  endfunction

endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic level
);

  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced;
  logic [CW-1:0]          run_q;
  logic                   level_q;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= line_in;
      end
    end
  endgenerate

  assign synced = sync_q[SYNC_STAGES-1];

  // accept a new level only after FILT_LEN consecutive differing samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      level_q <= 1'b1;
    end else if (synced == level_q) begin
      run_q <= '0;
    end else if (run_q == CW'(FILT_LEN - 1)) begin
      run_q   <= '0;
      level_q <= synced;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign level = level_q;

endmodule

// File: rtl/ps2_fall_detect.sv
module ps2_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic fall
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= level;
  end

  assign fall = prev_q & ~level;

endmodule

// File: rtl/ps2_tx_timer.sv
module ps2_tx_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/ps2_tx_seq.sv
module ps2_tx_seq
  import ps2tx_pkg::*;
#(
  parameter int INHIBIT_CYCLES = 5000,
  parameter int TIMEOUT_CYCLES = 750000,
  parameter int CNT_W          = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_start,
  input  logic              clk_fall,
  input  logic              dat_level,
  input  logic              timer_zero,
  output logic              timer_load,
  output logic [CNT_W-1:0]  timer_val,
  output logic              clk_pull,
  output logic              dat_pull,
  output logic              busy,
  output logic              done,
  output logic              ack_err,
  output logic              timeout_err
);

  tx_state_e          state_q;
  logic [FRAME_W-1:0] frame_q;
  logic [EDGE_W-1:0]  edge_q;
  logic               accept;
  logic               inhibit_end;
  logic               last_edge;

  assign accept      = (state_q == ST_IDLE) && tx_start;
  assign inhibit_end = (state_q == ST_INHIBIT) && timer_zero;
  assign last_edge   = (edge_q == EDGE_W'(LAST_EDGE - 1));

  assign timer_load = accept || inhibit_end || ((state_q == ST_XFER) && clk_fall);
  assign timer_val  = accept ? CNT_W'(INHIBIT_CYCLES - 1) : CNT_W'(TIMEOUT_CYCLES - 1);
  assign busy       = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      frame_q     <= '0;
      edge_q      <= '0;
      clk_pull    <= 1'b0;
      dat_pull    <= 1'b0;
      done        <= 1'b0;
      ack_err     <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (tx_start) begin
            state_q     <= ST_INHIBIT;
            frame_q     <= build_frame(tx_data);
            edge_q      <= '0;
            clk_pull    <= 1'b1;
            ack_err     <= 1'b0;
            timeout_err <= 1'b0;
          end
        end
        ST_INHIBIT: begin
          if (timer_zero) begin
            state_q  <= ST_XFER;
            clk_pull <= 1'b0;
            dat_pull <= 1'b1;
          end
        end
        ST_XFER: begin
          if (clk_fall) begin
            if (last_edge) begin
              state_q  <= ST_IDLE;
              dat_pull <= 1'b0;
              done     <= 1'b1;
              ack_err  <= dat_level;
            end else begin
              dat_pull <= ~frame_q[0];
              frame_q  <= frame_q >> 1;
              edge_q   <= edge_q + 1'b1;
            end
          end else if (timer_zero) begin
            state_q     <= ST_IDLE;
            dat_pull    <= 1'b0;
            done        <= 1'b1;
            timeout_err <= 1'b1;
          end
        end
        default: begin
          state_q  <= ST_IDLE;
          clk_pull <= 1'b0;
          dat_pull <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/ps2_host_tx.sv
module ps2_host_tx
  import ps2tx_pkg::*;
#(
  // must exceed SYNC_STAGES+FILT_LEN+1 so the host's own clock pull is filtered out
  parameter int INHIBIT_CYCLES = 5000,
  parameter int TIMEOUT_CYCLES = 750000,
  parameter int SYNC_STAGES    = 2,
  parameter int FILT_LEN       = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_start,
  input  logic              ps2_clk_in,
  input  logic              ps2_dat_in,
  output logic              ps2_clk_pull,
  output logic              ps2_dat_pull,
  output logic              busy,
  output logic              done,
  output logic              ack_err,
  output logic              timeout_err
);

  localparam int MAX_CNT = (INHIBIT_CYCLES > TIMEOUT_CYCLES) ? INHIBIT_CYCLES : TIMEOUT_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);

  logic [1:0]       line_raw;
  logic [1:0]       line_lvl;
  logic             clk_fall_evt;
  logic             timer_load;
  logic             timer_zero;
  logic [CNT_W-1:0] timer_val;

  assign line_raw = {ps2_dat_in, ps2_clk_in};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_line
      ps2_line_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .FILT_LEN   (FILT_LEN)
      ) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_in(line_raw[g]),
        .level  (line_lvl[g])
      );
    end
  endgenerate

  ps2_fall_detect u_fall (
    .clk  (clk),
    .rst_n(rst_n),
    .level(line_lvl[0]),
    .fall (clk_fall_evt)
  );

  ps2_tx_timer #(.W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (timer_load),
    .load_val(timer_val),
    .zero    (timer_zero)
  );

  ps2_tx_seq #(
    .INHIBIT_CYCLES(INHIBIT_CYCLES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .CNT_W         (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_data    (tx_data),
    .tx_start   (tx_start),
    .clk_fall   (clk_fall_evt),
    .dat_level  (line_lvl[1]),
    .timer_zero (timer_zero),
    .timer_load (timer_load),
    .timer_val  (timer_val),
    .clk_pull   (ps2_clk_pull),
    .dat_pull   (ps2_dat_pull),
    .busy       (busy),
    .done       (done),
    .ack_err    (ack_err),
    .timeout_err(timeout_err)
  );

endmodule

// File: rtl/ps2_host_tx_chk.sv
module ps2_host_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_start,
  input logic clk_pull,
  input logic dat_pull,
  input logic busy,
  input logic done,
  input logic ack_err,
  input logic timeout_err,
  input logic clk_fall
);

  AST_START_SEIZES_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tx_start) |=> (busy && clk_pull && !dat_pull)); // R2

  AST_START_BIT_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_pull) |-> (dat_pull && busy)); // R3

  AST_CLK_STAYS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clk_pull) |=> !clk_pull); // R4

  AST_DATA_MOVES_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !clk_pull && !$past(clk_pull) && !$past(clk_fall))
      |-> $stable(dat_pull)); // R5

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !clk_pull && !dat_pull)); // R8

  AST_NACK_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_err) |-> done); // R8

  AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> (done && !ack_err)); // R11

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_start && !clk_pull) |=> !clk_pull); // R12

  AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !tx_start) |=> ($stable(ack_err) && $stable(timeout_err))); // R13

endmodule

bind ps2_host_tx ps2_host_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_start   (tx_start),
  .clk_pull   (ps2_clk_pull),
  .dat_pull   (ps2_dat_pull),
  .busy       (busy),
  .done       (done),
  .ack_err    (ack_err),
  .timeout_err(timeout_err),
  .clk_fall   (clk_fall_evt)
);

// File: tb/ps2_host_tx_bench.sv
`timescale 1ns/1ps
module ps2_host_tx_bench;

  localparam int INH  = 40;
  localparam int TMO  = 300;
  localparam int SYN  = 2;
  localparam int FLT  = 3;
  localparam int LAT  = SYN + FLT + 1;  // R9 response latency in edges
  localparam int HALF = 20;             // device clock half period in cycles

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       tx_start = 1'b0;
  logic       dev_clk = 1'b1;
  logic       dev_dat = 1'b1;
  logic       ps2_clk_in, ps2_dat_in;
  logic       ps2_clk_pull, ps2_dat_pull, busy, done, ack_err, timeout_err;

  // expected outputs from the reference model
  logic e_clk = 0, e_dat = 0, e_busy = 0, e_done = 0, e_ack = 0, e_tmo = 0;
  int   checks = 0, errors = 0;
  string req = "R1";
  bit   in_xfer = 0;
  int   tmo_left = 0;
  logic [7:0] cur_byte;
  bit   cur_ack;
  bit   finished = 0;

  always #5 clk = ~clk;

  // open-collector wires: low if anyone pulls
  assign ps2_clk_in = ~ps2_clk_pull & dev_clk;
  assign ps2_dat_in = ~ps2_dat_pull & dev_dat;

  ps2_host_tx #(
    .INHIBIT_CYCLES(INH),
    .TIMEOUT_CYCLES(TMO),
    .SYNC_STAGES   (SYN),
    .FILT_LEN      (FLT)
  ) u_ps2_host_tx (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_start(tx_start),
    .ps2_clk_in(ps2_clk_in), .ps2_dat_in(ps2_dat_in),
    .ps2_clk_pull(ps2_clk_pull), .ps2_dat_pull(ps2_dat_pull),
    .busy(busy), .done(done), .ack_err(ack_err), .timeout_err(timeout_err)
  );

  task automatic cmp(input string name, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual=%b expected=%b", req, name, $time, act, exp);
    end
  endtask

  // compare every cycle, shortly after the active edge
  always begin
    @(posedge clk);
    #2;
    if (!finished) begin
      cmp("clk_pull", ps2_clk_pull, e_clk);
      cmp("dat_pull", ps2_dat_pull, e_dat);
      cmp("busy", busy, e_busy);
      cmp("done", done, e_done);
      cmp("ack_err", ack_err, e_ack);
      cmp("timeout_err", timeout_err, e_tmo);
    end
  end

  function automatic bit ref_parity(input logic [7:0] b);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += b[i];
    return (ones % 2 == 0);  // R6 total ones odd
  endfunction

  // one negedge step of the reference model, including the R11 timeout
  task automatic tick();
    @(negedge clk);
    if (e_done) e_done = 0;
    if (in_xfer) begin
      tmo_left--;
      if (tmo_left == 0) begin
        e_dat = 0; e_busy = 0; e_done = 1; e_tmo = 1; in_xfer = 0;  // R11
      end
    end
  endtask

  task automatic apply_edge(input int k);
    if (k <= 8)       e_dat = ~cur_byte[k-1];             // R5
    else if (k == 9)  e_dat = ~ref_parity(cur_byte);      // R6
    else if (k == 10) begin e_dat = 0; dev_dat = cur_ack ? 1'b0 : 1'b1; end  // R7
    else begin                                            // R8
      e_busy = 0; e_done = 1; e_ack = ~cur_ack; in_xfer = 0; dev_dat = 1'b1;
    end
    if (k < 11) tmo_left = TMO;
  endtask

  task automatic dev_fall(input int k, input int low_len);
    dev_clk = 1'b0;
    for (int i = 1; i <= 2*HALF; i++) begin
      tick();
      if (i == LAT - 1) apply_edge(k);   // R9 latency
      if (i == low_len) dev_clk = 1'b1;
    end
  endtask

  task automatic start_tx(input logic [7:0] b, input bit ack, input bit poke);
    tick();
    cur_byte = b; cur_ack = ack;
    tx_data = b; tx_start = 1'b1;
    e_busy = 1; e_clk = 1; e_ack = 0; e_tmo = 0;         // R2 R13
    tick();
    tx_start = 1'b0;
    for (int i = 2; i <= INH; i++) begin
      tick();
      if (poke && i == 10) begin tx_data = ~b; tx_start = 1'b1; end  // R12
      if (poke && i == 11) tx_start = 1'b0;
    end
    e_clk = 0; e_dat = 1; in_xfer = 1; tmo_left = TMO;   // R3
  endtask

  task automatic device_gap(input bit poke);
    for (int i = 0; i < 30; i++) begin
      tick();
      if (poke && i == 5) begin tx_data = 8'h81; tx_start = 1'b1; end  // R12
      if (poke && i == 6) tx_start = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(10);

    req = "R2 R3 R4 R5 R6 R7 R8 R9";
    start_tx(8'hA5, 1, 0);
    device_gap(0);
    for (int k = 1; k <= 11; k++) dev_fall(k, HALF);
    idle(10);

    req = "R8 R6 R13 nack";
    start_tx(8'h00, 0, 0);
    device_gap(0);
    for (int k = 1; k <= 11; k++) dev_fall(k, HALF);
    idle(40);

    req = "R10 R12 R13";
    start_tx(8'hFF, 1, 1);
    device_gap(1);
    for (int k = 1; k <= 11; k++) begin
      if (k == 5) dev_fall(k, FLT);   // pulse of exactly FILT_LEN counts
      else        dev_fall(k, HALF);
      if (k == 3 || k == 7) begin     // short glitch must not advance the frame
        dev_clk = 1'b0; tick(); tick(); dev_clk = 1'b1; idle(10);
      end
    end
    idle(10);

    req = "R11 no edges";
    start_tx(8'h5A, 1, 0);
    idle(TMO + 20);

    req = "R11 mid-frame";
    start_tx(8'hC3, 1, 0);
    device_gap(0);
    for (int k = 1; k <= 4; k++) dev_fall(k, HALF);
    idle(TMO + 20);

    req = "R13 R5 after timeout";
    start_tx(8'h3C, 1, 0);
    device_gap(0);
    for (int k = 1; k <= 11; k++) dev_fall(k, HALF);
    idle(10);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog %s: actual=running expected=finished", req);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule